// File: doc/BRIEF.md
# CEC Bus Byte Transmitter

This block sends consumer-electronics-control frames onto a shared open-drain line, one byte at a time. All bus timing is counted in a slow sampling tick of about 32.768 kHz, which arrives as a one-cycle enable on the fast system clock. After a start request, the block waits until the line has stayed high for a programmable number of bit periods. It then pulls the line down for the start bit and sends blocks. Each block holds eight data bits with the most significant bit first, then the end-of-message bit, then an acknowledge slot.

The low time of a logical 1 and of a logical 0, and the length of a bit, are set in ticks. While the block has released the line it reads the line back. A low reading during a bit it drives itself means another initiator has won the bus. The reading in the acknowledge slot is compared against the response expected for a directly addressed or a broadcast frame. Either error releases the line, ends the frame and sets a sticky flag. A fresh byte is captured at the start of every block, and a one-cycle request then asks the host for the byte after it.

Top module: `cec_byte_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, `line_pull` is 0, `busy` is 0, and both error flags are 0 until an error occurs.
- R2: After `start_req`, the start bit begins only once the line has been read high on `free_bits * cycle_cfg` consecutive ticks. Any low reading restarts that count.
- R3: The start bit holds the line low for START_LOW ticks, and the next bit begins START_CYCLE ticks after the start bit began.
- R4: Data bits go out most significant bit first. A 1 is low for `rise1_cfg` ticks and a 0 is low for `rise0_cfg` ticks, and every bit lasts `cycle_cfg` ticks.
- R5: The ninth bit of a block carries the captured end-of-message value. The tenth bit, the acknowledge slot, is driven as a logical 1 (low for `rise1_cfg` ticks).
- R6: At the first tick of each block, `tx_byte` and `tx_eom` are captured and `byte_req` pulses high for exactly one clock.
- R7: When the acknowledge slot of a block whose end-of-message bit was 1 completes, `frame_done` pulses for one clock and `busy` falls. Otherwise the next block follows at once.
- R8: If the line reads low on a tick while the block has released it, in any bit other than the acknowledge slot, `err_arb` is set and the frame is abandoned with the line released.
- R9: For a frame started with `tx_bcast`=0, a high line at the acknowledge sample point sets `err_ack` and abandons the frame.
- R10: For a frame started with `tx_bcast`=1, a low line at the acknowledge sample point sets `err_ack` and abandons the frame. A high line there lets the frame continue.
- R11: Error flags stay set until `err_clr` is asserted. An abandoned frame leaves `line_pull` at 0.
- R12: A `start_req` while `busy` is 1 has no effect. The running frame is unchanged and no second frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle bus timing enable (about 32.768 kHz) |
| line_in | input | 1 | Synchronised readback of the bus line |
| start_req | input | 1 | Request to send a frame |
| err_clr | input | 1 | Clears both error flags |
| tx_byte | input | 8 | Byte for the next block |
| tx_eom | input | 1 | End-of-message value for the next block |
| tx_bcast | input | 1 | Frame is broadcast (inverts the acknowledge judgement) |
| rise1_cfg | input | CW | Low time of a logical 1, in ticks |
| rise0_cfg | input | CW | Low time of a logical 0, in ticks |
| cycle_cfg | input | CW | Bit length in ticks |
| free_bits | input | FREE_W | Bus-free wait in bit periods |
| line_pull | output | 1 | 1 pulls the open-drain line low |
| busy | output | 1 | Frame in progress (waiting or sending) |
| byte_req | output | 1 | One-clock request for the following byte |
| frame_done | output | 1 | One-clock pulse at the normal end of a frame |
| err_arb | output | 1 | Sticky arbitration-loss flag |
| err_ack | output | 1 | Sticky acknowledge-response flag |

## Verification
Two things can happen on the same tick. The acknowledge judgement on a broadcast frame and the arbitration check on the bits around it both read the same line readback, and the model follower is placed so that its low pulse covers the sample point but ends inside the slot. A second overlap comes from a `start_req` pulsed in the middle of a frame while the block is busy, which lands on top of a bit boundary. The bench decodes every low time and bit period from the line itself and compares them with values worked out from the tick settings. Each run is judged by that decode, by the number of falling edges on the line, and by the byte-request and done counts.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FREE  = 2'd1,
      ST_START = 2'd2,
      ST_BITS  = 2'd3
   } tx_state_t;

   localparam int BITS_PER_BLOCK = 10;
   localparam int EOM_IDX        = 8;
   localparam int ACK_IDX        = 9;
endpackage

// File: rtl/cec_tx_bittimer.sv
module cec_tx_bittimer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          run,
   input  logic [CW-1:0] cyc_len,
   output logic [CW-1:0] cnt,
   output logic          last
);
   assign last = run && tick && (cnt == cyc_len - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run)
         cnt <= '0;
      else if (tick)
         cnt <= last ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/cec_tx_freedet.sv
module cec_tx_freedet #(
   parameter int TW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          en,
   input  logic          line_in,
   input  logic [TW-1:0] target,
   output logic          hit
);
   logic [TW-1:0] high_cnt;

   assign hit = en && tick && line_in && (high_cnt == target - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         high_cnt <= '0;
      else if (!en)
         high_cnt <= '0;
      else if (tick)
         high_cnt <= line_in ? high_cnt + 1'b1 : '0;
   end
endmodule

// File: rtl/cec_tx_ackjudge.sv
module cec_tx_ackjudge (
   input  logic bcast,
   input  logic line_in,
   output logic bad
);
   // directed: follower must pull low; broadcast: low means a rejection
   assign bad = bcast ? !line_in : line_in;
endmodule

// File: rtl/cec_byte_tx.sv
module cec_byte_tx #(
   parameter int CW          = 8,
   parameter int FREE_W      = 3,
   parameter int START_LOW   = 121,
   parameter int START_CYCLE = 147,
   parameter bit SAMPLE_MID  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              line_in,
   input  logic              start_req,
   input  logic              err_clr,
   input  logic [7:0]        tx_byte,
   input  logic              tx_eom,
   input  logic              tx_bcast,
   input  logic [CW-1:0]     rise1_cfg,
   input  logic [CW-1:0]     rise0_cfg,
   input  logic [CW-1:0]     cycle_cfg,
   input  logic [FREE_W-1:0] free_bits,
   output logic              line_pull,
   output logic              busy,
   output logic              byte_req,
   output logic              frame_done,
   output logic              err_arb,
   output logic              err_ack
);
   import cec_tx_pkg::*;

   localparam int TW = CW + FREE_W;
   localparam logic [CW-1:0] SL_C = CW'(START_LOW);
   localparam logic [CW-1:0] SC_C = CW'(START_CYCLE);

   generate
      if (START_LOW < 1 || START_LOW >= START_CYCLE) begin : g_bad_start
         $error("start low time must be positive and shorter than the start cycle");
      end
      if (START_CYCLE >= (1 << CW)) begin : g_bad_width
         $error("start cycle does not fit the tick counter width");
      end
      if (FREE_W < 1) begin : g_bad_free
         $error("bus-free field needs at least one bit");
      end
   endgenerate

   tx_state_t     st;
   logic [3:0]    bidx;
   logic [7:0]    shreg;
   logic          eom_q, bcast_q;
   logic          run, last, free_hit, ack_bad, cur_bit, in_ack;
   logic          arb_hit, ack_tick;
   logic [CW-1:0] cnt, low_len, cyc_len, samp_pt;
   logic [TW-1:0] free_target;

   assign run         = (st == ST_START) || (st == ST_BITS);
   assign in_ack      = (st == ST_BITS) && (bidx == 4'(ACK_IDX));
   assign busy        = (st != ST_IDLE);
   assign free_target = TW'(free_bits) * TW'(cycle_cfg);

   always_comb begin
      if (bidx < 4'(EOM_IDX))       cur_bit = shreg[7];
      else if (bidx == 4'(EOM_IDX)) cur_bit = eom_q;
      else                          cur_bit = 1'b1;
      if (st == ST_START) begin
         low_len = SL_C;
         cyc_len = SC_C;
      end else begin
         low_len = cur_bit ? rise1_cfg : rise0_cfg;
         cyc_len = cycle_cfg;
      end
   end

   generate
      if (SAMPLE_MID) begin : g_samp_mid
         assign samp_pt = CW'(({1'b0, rise1_cfg} + {1'b0, rise0_cfg}) >> 1);
      end else begin : g_samp_late
         assign samp_pt = rise0_cfg - 1'b1;
      end
   endgenerate

   assign line_pull = run && (cnt < low_len);
   assign arb_hit   = tick && run && !in_ack && (cnt >= low_len) && !line_in;
   assign ack_tick  = tick && in_ack && (cnt == samp_pt);

   cec_tx_bittimer #(.CW(CW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
      .cyc_len(cyc_len), .cnt(cnt), .last(last)
   );

   cec_tx_freedet #(.TW(TW)) u_free (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(st == ST_FREE),
      .line_in(line_in), .target(free_target), .hit(free_hit)
   );

   cec_tx_ackjudge u_ack (
      .bcast(bcast_q), .line_in(line_in), .bad(ack_bad)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         bidx       <= '0;
         shreg      <= '0;
         eom_q      <= 1'b0;
         bcast_q    <= 1'b0;
         byte_req   <= 1'b0;
         frame_done <= 1'b0;
         err_arb    <= 1'b0;
         err_ack    <= 1'b0;
      end else begin
         byte_req   <= 1'b0;
         frame_done <= 1'b0;
         if (err_clr) begin
            err_arb <= 1'b0;
            err_ack <= 1'b0;
         end
         unique case (st)
            ST_IDLE: begin
               if (start_req) begin
                  st      <= ST_FREE;
                  bcast_q <= tx_bcast;
               end
            end
            ST_FREE: begin
               if (free_hit) st <= ST_START;
            end
            ST_START: begin
               if (arb_hit) begin
                  st      <= ST_IDLE;
                  err_arb <= 1'b1;
               end else if (last) begin
                  st       <= ST_BITS;
                  bidx     <= '0;
                  shreg    <= tx_byte;
                  eom_q    <= tx_eom;
                  byte_req <= 1'b1;
               end
            end
            ST_BITS: begin
               if (arb_hit) begin
                  st      <= ST_IDLE;
                  err_arb <= 1'b1;
               end else if (ack_tick && ack_bad) begin
                  st      <= ST_IDLE;
                  err_ack <= 1'b1;
               end else if (last) begin
                  if (in_ack) begin
                     if (eom_q) begin
                        st         <= ST_IDLE;
                        frame_done <= 1'b1;
                     end else begin
                        bidx     <= '0;
                        shreg    <= tx_byte;
                        eom_q    <= tx_eom;
                        byte_req <= 1'b1;
                     end
                  end else begin
                     bidx <= bidx + 1'b1;
                     if (bidx < 4'(EOM_IDX)) shreg <= {shreg[6:0], 1'b0};
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cec_byte_tx_chk.sv
module cec_byte_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic err_clr,
   input logic line_pull,
   input logic busy,
   input logic byte_req,
   input logic frame_done,
   input logic err_arb,
   input logic err_ack
);
   a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !line_pull);

   a_r4_edge_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_pull) |-> $past(tick));

   a_r6_req_single: assert property (@(posedge clk) disable iff (!rst_n)
      byte_req |=> !byte_req);

   a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> (!busy && !line_pull));

   a_r8_arb_abandon: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_arb) |-> (!busy && !line_pull));

   a_r9_ack_abandon: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_ack) |-> (!busy && !line_pull));

   a_r11_hold_arb: assert property (@(posedge clk) disable iff (!rst_n)
      (err_arb && !err_clr) |=> err_arb);

   a_r11_hold_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (err_ack && !err_clr) |=> err_ack);
endmodule

bind cec_byte_tx cec_byte_tx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .err_clr(err_clr),
   .line_pull(line_pull), .busy(busy), .byte_req(byte_req),
   .frame_done(frame_done), .err_arb(err_arb), .err_ack(err_ack)
);

// File: tb/sim_cec_byte_tx.sv
`timescale 1ns/1ps
module sim_cec_byte_tx;
   localparam int CW = 8;
   localparam int FW = 3;
   localparam int SL = 6;
   localparam int SC = 9;

   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
   always #2.5 clk = ~clk;
   always @(posedge clk) tick <= ~tick;

   logic line_pull, busy, byte_req, frame_done, err_arb, err_ack;
   logic other_pull = 1'b0, fol_pull = 1'b0, fol_en = 1'b0;
   logic start_req = 1'b0, err_clr = 1'b0, tx_bcast = 1'b0, mon_clr = 1'b0;
   logic [CW-1:0] r1 = 8'd2, r0 = 8'd5, cyc = 8'd8;
   logic [FW-1:0] fbits = 3'd3;
   logic [7:0] fb [0:3];
   int fn = 1, bsel = 0;
   logic [7:0] tx_byte;
   logic tx_eom;
   wire line = !(line_pull || other_pull || fol_pull);
   assign tx_byte = fb[bsel[1:0]];
   assign tx_eom  = (bsel == fn - 1);

   int nchk = 0, nerr = 0;
   int nfall, low_t, per_t, hi_t, free_seen, breq_cnt, done_cnt;
   int lows [0:63];
   int pers [0:63];
   logic line_q = 1'b1;
   int fcnt = 0, fol_last = 0;

   cec_byte_tx #(.CW(CW), .FREE_W(FW), .START_LOW(SL), .START_CYCLE(SC), .SAMPLE_MID(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .line_in(line), .start_req(start_req),
      .err_clr(err_clr), .tx_byte(tx_byte), .tx_eom(tx_eom), .tx_bcast(tx_bcast),
      .rise1_cfg(r1), .rise0_cfg(r0), .cycle_cfg(cyc), .free_bits(fbits),
      .line_pull(line_pull), .busy(busy), .byte_req(byte_req), .frame_done(frame_done),
      .err_arb(err_arb), .err_ack(err_ack)
   );

   // line decoder: low times and periods in ticks, sampled away from the edge
   always @(negedge clk) begin
      if (mon_clr) begin
         nfall = 0; low_t = 0; per_t = 0; hi_t = 0; free_seen = -1;
         breq_cnt = 0; done_cnt = 0; bsel = 0;
      end else begin
         if (!line && line_q) begin
            if (nfall > 0 && nfall <= 64) pers[nfall-1] = per_t;
            if (nfall == 0) free_seen = hi_t;
            nfall++;
            per_t = tick ? 1 : 0;
            low_t = tick ? 1 : 0;
         end else begin
            if (line && !line_q && nfall > 0 && nfall <= 64) lows[nfall-1] = low_t;
            if (tick) begin
               per_t++;
               if (!line) low_t++;
               if (line && nfall == 0) hi_t++;
            end
            if (!line && nfall == 0) hi_t = 0;
         end
         if (byte_req) begin breq_cnt++; bsel++; end
         if (frame_done) done_cnt++;
      end
      line_q = line;
   end

   // follower model: pulls low through each acknowledge slot when enabled
   always @(posedge clk) begin
      if (mon_clr) begin
         fol_last <= 0; fol_pull <= 1'b0;
      end else if (fol_en && nfall > 1 && nfall != fol_last && ((nfall - 1) % 10) == 0) begin
         fol_pull <= 1'b1; fcnt <= r0 + 1; fol_last <= nfall;
      end else if (fol_pull && tick) begin
         if (fcnt <= 1) fol_pull <= 1'b0;
         fcnt <= fcnt - 1;
      end
   end

   task automatic chk(input string what, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic finish_sim();
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   endtask

   task automatic do_frame(input int n, input bit bc, input bit fol, input int hold,
                           input bit mid, input int arb_at);
      bit mid_done = 0, arbd = 0;
      int ocnt = 0;
      fn = n; tx_bcast = bc; fol_en = fol;
      other_pull = 1'b1; start_req = 1'b1;
      @(negedge clk); start_req = 1'b0; mon_clr = 1'b1;
      @(negedge clk); mon_clr = 1'b0;
      repeat (hold) @(negedge clk);
      other_pull = 1'b0;
      for (int k = 0; k < 8000; k++) begin
         @(negedge clk);
         start_req = 1'b0;
         if (mid && !mid_done && nfall == 5) begin start_req = 1'b1; mid_done = 1; end
         if (arb_at > 0 && !arbd && nfall == arb_at) begin other_pull = 1'b1; ocnt = 12; arbd = 1; end
         else if (ocnt > 0) begin ocnt--; if (ocnt == 0) other_pull = 1'b0; end
         if (!busy && ocnt == 0 && k > 2) break;
      end
      start_req = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic check_frame(input bit fol);
      chk("R2 bus-free high ticks", free_seen, int'(fbits) * int'(cyc));
      chk("R3 start low ticks", lows[0], SL);
      chk("R3 start cycle ticks", pers[0], SC);
      chk("R7 falling edges in frame", nfall, 1 + 10 * fn);
      for (int b = 0; b < fn; b++) begin
         for (int i = 0; i < 10; i++) begin
            int f = 1 + 10 * b + i;
            bit eb = (i < 8) ? fb[b][7-i] : ((i == 8) ? (b == fn - 1) : 1'b1);
            if (i < 8)       chk("R4 data bit low ticks", lows[f], eb ? int'(r1) : int'(r0));
            else if (i == 8) chk("R5 eom bit low ticks", lows[f], eb ? int'(r1) : int'(r0));
            else if (!fol)   chk("R5 ack slot driven as one", lows[f], int'(r1));
            if (f < nfall - 1) chk("R4 bit cycle ticks", pers[f], int'(cyc));
         end
      end
      chk("R6 byte requests", breq_cnt, fn);
      chk("R7 done pulses", done_cnt, 1);
      chk("R7 busy low at end", busy, 0);
      chk("R8 no arbitration flag", err_arb, 0);
      chk("R9 no ack flag", err_ack, 0);
   endtask

   task automatic clear_flags();
      @(negedge clk); err_clr = 1'b1;
      @(negedge clk); err_clr = 1'b0;
   endtask

   initial begin
      #(150000 * 5);
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
   end

   initial begin
      mon_clr = 1'b1;
      repeat (10) @(negedge clk);
      chk("R1 reset pull", line_pull, 0);
      chk("R1 reset busy", busy, 0);
      chk("R1 reset arb flag", err_arb, 0);
      chk("R1 reset ack flag", err_ack, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      mon_clr = 1'b0;
      chk("R1 idle pull", line_pull, 0);
      chk("R6 idle byte request", byte_req, 0);

      // timing sweep, directed frames acknowledged by the follower
      for (int c = 0; c < 8; c++) begin
         int n = 1 + c % 3;
         r1 = 8'(1 + (c & 1));
         r0 = r1 + 8'(2 + ((c >> 1) & 1));
         cyc = r0 + 8'(2 + ((c >> 2) & 1));
         fbits = 3'(2 + c % 3);
         fb[0] = 8'(c * 37 + 5);
         fb[1] = ~fb[0] ^ 8'h5A;
         fb[2] = 8'(c * 11);
         fb[3] = 8'h00;
         do_frame(n, 1'b0, 1'b1, 3 + c, c == 2, 0);
         check_frame(1'b1);
         if (c == 2) begin
            repeat (200) @(negedge clk);
            chk("R12 stray start left no frame", busy, 0);
            chk("R12 stray start left no edges", nfall, 1 + 10 * n);
         end
      end

      r1 = 8'd2; r0 = 8'd5; cyc = 8'd8; fbits = 3'd3;

      // broadcast without rejection: frame completes
      fb[0] = 8'h0F; fb[1] = 8'hF0;
      do_frame(2, 1'b1, 1'b0, 3, 1'b0, 0);
      check_frame(1'b0);
      chk("R10 broadcast accepted", err_ack, 0);

      // broadcast rejected by a low acknowledge slot
      fb[0] = 8'h3C;
      do_frame(2, 1'b1, 1'b1, 3, 1'b0, 0);
      chk("R10 broadcast reject flag", err_ack, 1);
      chk("R10 stopped after first block", nfall, 11);
      chk("R11 line released after reject", line, 1);
      clear_flags();
      chk("R11 ack flag cleared", err_ack, 0);

      // directed frame without acknowledge
      fb[0] = 8'hA5;
      do_frame(2, 1'b0, 1'b0, 3, 1'b0, 0);
      chk("R9 missing ack flag", err_ack, 1);
      chk("R9 stopped after first block", nfall, 11);
      chk("R9 busy low", busy, 0);
      chk("R11 line released after ack error", line, 1);
      repeat (60) @(negedge clk);
      chk("R11 ack flag held", err_ack, 1);
      clear_flags();
      chk("R11 ack flag cleared", err_ack, 0);

      // arbitration loss during the second data bit (a one)
      fb[0] = 8'hFF;
      do_frame(1, 1'b0, 1'b1, 3, 1'b0, 3);
      chk("R8 arbitration flag", err_arb, 1);
      chk("R8 no ack flag", err_ack, 0);
      chk("R8 no edges after loss", nfall, 3);
      chk("R8 busy low", busy, 0);
      chk("R11 line released after loss", line_pull, 0);
      repeat (60) @(negedge clk);
      chk("R11 arb flag held", err_arb, 1);
      clear_flags();
      chk("R11 arb flag cleared", err_arb, 0);

      // normal frame after errors
      fb[0] = 8'h81;
      do_frame(1, 1'b0, 1'b1, 2, 1'b0, 0);
      check_frame(1'b1);

      finish_sim();
   end
endmodule